// File: doc/BRIEF.md
# Three-Sample Bang-Bang Phase Detector

This block is the digital decision core of a bang-bang clock and data recovery loop. For every bit period it receives three samples of the incoming waveform: one taken at the middle of the current bit (A), one taken near the boundary to the following bit (T), and one taken at the middle of the following bit (B). If A and B differ, a transition lies between them, and T shows which side of that transition the clock fell on. When T matches A, the clock is early and a slow-down correction is issued. When T matches B, the clock is late and a speed-up correction is issued. If A equals B, there was no transition and the loop takes no action.

Each correction acts as a proportional kick of fixed size that lasts one bit. The corrections also feed a signed saturating integrator, whose value steers the oscillator centre frequency. The A sample is the retrieved data bit and is sent out on a valid/ready stream. A bit with A equal to B but T different from both marks a sampling inconsistency, which is reported on a one-cycle error flag for bit-error monitoring. An external frequency-window qualifier can hold off all corrections while acquisition is handled elsewhere.

The sample stream is valid/ready. A bit is accepted on a clock edge where `s_valid` and `s_ready` are both high. The output stage is one register deep, and `s_ready` is high whenever that register is empty or is being drained in the same cycle (`m_ready` high). While the output holds a beat that the sink refuses, no new bit is taken, and neither the corrections nor the integrator move.

Top module: `bbpd_top`

## Requirements
- R1: A bit accepted with A equal to B produces neither an up nor a down pulse in the following cycle, whatever T is.
- R2: A bit accepted with A equal to T and different from B, while `win_ok` is high, raises `corr_dn` and drives `prop_ctl` to minus PROP_STEP in the cycle after acceptance.
- R3: A bit accepted with T equal to B and different from A, while `win_ok` is high, raises `corr_up` and drives `prop_ctl` to plus PROP_STEP in the cycle after acceptance.
- R4: Each correction pulse lasts exactly one clock per accepted bit. In a cycle that follows an edge with no accepted bit, `corr_up`, `corr_dn` and `err_flag` are low and `prop_ctl` is zero.
- R5: `freq_ctl` resets to zero. It rises by one for each up pulse, falls by one for each down pulse, and is otherwise unchanged.
- R6: `freq_ctl` saturates. An up pulse at 2^(INT_W-1)-1 and a down pulse at -2^(INT_W-1) leave it unchanged.
- R7: `m_data` carries the A sample of the most recently accepted bit, with `m_valid` high from the cycle after acceptance.
- R8: A bit accepted with A equal to B and T different from both raises `err_flag` for one cycle after acceptance, regardless of `win_ok`.
- R9: While `win_ok` is low, accepted bits produce no up or down pulse and leave `freq_ctl` unchanged. Data is still delivered.
- R10: `s_ready` equals `!m_valid || m_ready`. While `m_valid` is high and `m_ready` is low, `m_data` holds and no bit is accepted.
- R11: `corr_up` and `corr_dn` are never high in the same cycle.
- R12: A run of at least 2000 accepted bits with no transition (A equal to B) leaves `freq_ctl` at its starting value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample triple valid |
| s_ready | output | 1 | Block can accept a sample triple |
| s_a | input | 1 | Sample at centre of current bit |
| s_t | input | 1 | Sample near the following transition |
| s_b | input | 1 | Sample at centre of next bit |
| win_ok | input | 1 | Frequency window good; low suppresses corrections |
| m_valid | output | 1 | Retrieved data beat valid |
| m_ready | input | 1 | Sink accepts the data beat |
| m_data | output | 1 | Retrieved data bit (A sample) |
| corr_up | output | 1 | Speed-up pulse, one clock per accepted late bit |
| corr_dn | output | 1 | Slow-down pulse, one clock per accepted early bit |
| prop_ctl | output | PROP_W | Signed proportional step for the current pulse |
| freq_ctl | output | INT_W | Signed saturating integral frequency word |
| err_flag | output | 1 | Inconsistent-sample event for the accepted bit |

## Verification
If the decision state is wrong, a wrong or missing `corr_up`/`corr_dn` and a wrong `prop_ctl` sign show up in the very cycle after the offending bit. The integrator then differs from the bench's running count by one on that same cycle. A fault in the integrator is visible on `freq_ctl` one cycle after the first step it mishandles. A saturation or wrap fault only appears once the bound is reached, so the bench drives the word to both rails. A stuck or leaky output register shows up within one cycle as a changed `m_data` or a wrong `s_ready` while the sink stalls.

// File: rtl/bbpd_pkg.sv
package bbpd_pkg;

  // Correction direction decided for one bit.
  typedef enum logic [1:0] {
    CORR_NONE = 2'd0,
    CORR_UP   = 2'd1,
    CORR_DN   = 2'd2
  } corr_e;

  // Per-bit decision result.
  typedef struct packed {
    logic  data;
    logic  err;
    corr_e corr;
  } bit_res_t;

endpackage

// File: rtl/bbpd_decide.sv
module bbpd_decide
  import bbpd_pkg::*;
(
  input  logic     a_i,
  input  logic     t_i,
  input  logic     b_i,
  input  logic     win_ok_i,
  output bit_res_t res_o
);

  logic trans;

  always_comb begin
    trans      = a_i ^ b_i;
    res_o.data = a_i;
    // No transition, yet the boundary sample disagrees: a suspect bit.
    res_o.err  = !trans && (t_i != a_i);
    res_o.corr = CORR_NONE;
    if (win_ok_i && trans) begin
      // T on the A side: clock sampled before the edge, so it is early.
      res_o.corr = (t_i == a_i) ? CORR_DN : CORR_UP;
    end
  end

endmodule

// File: rtl/bbpd_integ.sv
module bbpd_integ #(
  parameter int INT_W    = 8,
  parameter bit SATURATE = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step_en,
  input  logic                    step_up,
  output logic signed [INT_W-1:0] acc_o
);

  localparam logic signed [INT_W-1:0] MAXV = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic signed [INT_W-1:0] MINV = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic signed [INT_W-1:0] ONE  = INT_W'(1);

  logic signed [INT_W-1:0] acc_q;
  logic signed [INT_W-1:0] acc_d;

  generate
    if (SATURATE) begin : g_sat
      always_comb begin
        acc_d = acc_q;
        if (step_en) begin
          if (step_up) acc_d = (acc_q == MAXV) ? acc_q : acc_q + ONE;
          else         acc_d = (acc_q == MINV) ? acc_q : acc_q - ONE;
        end
      end

      assert_sat_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && step_up && acc_q == MAXV) |=> (acc_q == MAXV));
      assert_sat_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !step_up && acc_q == MINV) |=> (acc_q == MINV));
    end else begin : g_wrap
      always_comb begin
        acc_d = acc_q;
        if (step_en) acc_d = step_up ? acc_q + ONE : acc_q - ONE;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(acc_q));

endmodule

// File: rtl/bbpd_pulse.sv
module bbpd_pulse
  import bbpd_pkg::*;
#(
  parameter int PROP_W    = 8,
  parameter int PROP_STEP = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_i,
  input  corr_e                    corr_i,
  input  logic                     err_i,
  output logic                     up_o,
  output logic                     dn_o,
  output logic                     err_o,
  output logic signed [PROP_W-1:0] prop_o
);

  localparam logic signed [PROP_W-1:0] STEP_V = PROP_W'(PROP_STEP);

  logic                     up_q, dn_q, err_q;
  logic signed [PROP_W-1:0] prop_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_q   <= 1'b0;
      dn_q   <= 1'b0;
      err_q  <= 1'b0;
      prop_q <= '0;
    end else begin
      up_q  <= load_i && (corr_i == CORR_UP);
      dn_q  <= load_i && (corr_i == CORR_DN);
      err_q <= load_i && err_i;
      if (load_i && corr_i == CORR_UP)      prop_q <= STEP_V;
      else if (load_i && corr_i == CORR_DN) prop_q <= -STEP_V;
      else                                  prop_q <= '0;
    end
  end

  assign up_o   = up_q;
  assign dn_o   = dn_q;
  assign err_o  = err_q;
  assign prop_o = prop_q;

  assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({up_q, dn_q}));
  assert_idle_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> (!up_q && !dn_q && !err_q && prop_q == '0));

endmodule

// File: rtl/bbpd_outreg.sv
module bbpd_outreg (
  input  logic clk,
  input  logic rst_n,
  input  logic s_valid,
  output logic s_ready,
  input  logic s_data,
  output logic m_valid,
  input  logic m_ready,
  output logic m_data
);

  logic vld_q, dat_q;
  logic take;

  assign s_ready = !vld_q || m_ready;
  assign take    = s_valid && s_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= 1'b0;
    end else begin
      if (take)         vld_q <= 1'b1;
      else if (m_ready) vld_q <= 1'b0;
      if (take)         dat_q <= s_data;
    end
  end

  assign m_valid = vld_q;
  assign m_data  = dat_q;

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !m_ready) |=> (vld_q && $stable(dat_q)));

endmodule

// File: rtl/bbpd_top.sv
module bbpd_top
  import bbpd_pkg::*;
#(
  parameter int INT_W     = 8,
  parameter int PROP_W    = 8,
  parameter int PROP_STEP = 4,
  parameter bit SATURATE  = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s_valid,
  output logic                     s_ready,
  input  logic                     s_a,
  input  logic                     s_t,
  input  logic                     s_b,
  input  logic                     win_ok,
  output logic                     m_valid,
  input  logic                     m_ready,
  output logic                     m_data,
  output logic                     corr_up,
  output logic                     corr_dn,
  output logic signed [PROP_W-1:0] prop_ctl,
  output logic signed [INT_W-1:0]  freq_ctl,
  output logic                     err_flag
);

  localparam logic signed [PROP_W-1:0] STEP_V = PROP_W'(PROP_STEP);

  bit_res_t res;
  logic     accept;

  assign accept = s_valid && s_ready;

  bbpd_decide u_decide (
    .a_i      (s_a),
    .t_i      (s_t),
    .b_i      (s_b),
    .win_ok_i (win_ok),
    .res_o    (res)
  );

  bbpd_outreg u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (s_valid),
    .s_ready (s_ready),
    .s_data  (res.data),
    .m_valid (m_valid),
    .m_ready (m_ready),
    .m_data  (m_data)
  );

  bbpd_pulse #(.PROP_W(PROP_W), .PROP_STEP(PROP_STEP)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .corr_i (res.corr),
    .err_i  (res.err),
    .up_o   (corr_up),
    .dn_o   (corr_dn),
    .err_o  (err_flag),
    .prop_o (prop_ctl)
  );

  bbpd_integ #(.INT_W(INT_W), .SATURATE(SATURATE)) u_integ (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (accept && res.corr != CORR_NONE),
    .step_up (res.corr == CORR_UP),
    .acc_o   (freq_ctl)
  );

  assert_no_trans_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && s_a == s_b) |=> (!corr_up && !corr_dn));
  assert_early_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && win_ok && s_a == s_t && s_t != s_b) |=> (corr_dn && prop_ctl == -STEP_V));
  assert_late_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && win_ok && s_t == s_b && s_t != s_a) |=> (corr_up && prop_ctl == STEP_V));
  assert_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (m_valid && m_data == $past(s_a)));
  assert_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && s_a == s_b && s_t != s_a) |=> err_flag);
  assert_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !win_ok) |=> (!corr_up && !corr_dn && $stable(freq_ctl)));
  assert_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready == (!m_valid || m_ready));

endmodule

// File: tb/tb_bbpd_top.sv
module tb_bbpd_top;

  localparam int INT_W = 8;
  localparam int PROP_W = 8;
  localparam int STEP = 4;
  localparam int MAXV = 127;
  localparam int MINV = -128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0, s_a = 1'b0, s_t = 1'b0, s_b = 1'b0, win_ok = 1'b1;
  logic m_ready = 1'b1;
  logic s_ready, m_valid, m_data, corr_up, corr_dn, err_flag;
  logic signed [PROP_W-1:0] prop_ctl;
  logic signed [INT_W-1:0]  freq_ctl;

  int checks = 0;
  int fails = 0;
  int exp_int = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bbpd_top #(.INT_W(INT_W), .PROP_W(PROP_W), .PROP_STEP(STEP)) dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_a(s_a), .s_t(s_t), .s_b(s_b), .win_ok(win_ok),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .corr_up(corr_up), .corr_dn(corr_dn), .prop_ctl(prop_ctl),
    .freq_ctl(freq_ctl), .err_flag(err_flag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One accepted bit with m_ready high, checked against the reference model.
  task automatic send(input logic a, input logic t, input logic b, input logic w);
    int eu, ed, ee;
    @(negedge clk);
    s_valid = 1'b1; s_a = a; s_t = t; s_b = b; win_ok = w;
    @(posedge clk); #1;
    s_valid = 1'b0;
    eu = (w && a != b && t == b) ? 1 : 0;
    ed = (w && a != b && t == a) ? 1 : 0;
    ee = (a == b && t != a) ? 1 : 0;
    if (eu == 1 && exp_int < MAXV) exp_int++;
    if (ed == 1 && exp_int > MINV) exp_int--;
    chk("R3 up pulse", int'(corr_up), eu);
    chk("R2 dn pulse", int'(corr_dn), ed);
    chk("R2 R3 prop step", int'(prop_ctl), eu ? STEP : (ed ? -STEP : 0));
    chk("R11 exclusive", int'(corr_up & corr_dn), 0);
    chk("R8 err flag", int'(err_flag), ee);
    chk("R7 data", int'(m_data), int'(a));
    chk("R7 valid", int'(m_valid), 1);
    chk("R5 freq word", int'(freq_ctl), exp_int);
  endtask

  task automatic t_reset;
    chk("R5 reset freq", int'(freq_ctl), 0);
    chk("R10 reset valid", int'(m_valid), 0);
    chk("R10 reset ready", int'(s_ready), 1);
    chk("R4 reset pulses", int'(corr_up | corr_dn | err_flag), 0);
    chk("R4 reset prop", int'(prop_ctl), 0);
  endtask

  task automatic t_no_transition;  // R1, R8
    for (int i = 0; i < 4; i++) send(i[1], i[0], i[1], 1'b1);
  endtask

  task automatic t_early_late;  // R2, R3, R5
    send(1'b1, 1'b1, 1'b0, 1'b1);
    send(1'b0, 1'b0, 1'b1, 1'b1);
    send(1'b0, 1'b1, 1'b1, 1'b1);
    send(1'b1, 1'b0, 1'b0, 1'b1);
    send(1'b0, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_pulse_width;  // R4
    send(1'b0, 1'b1, 1'b1, 1'b1);
    @(posedge clk); #1;
    chk("R4 up cleared", int'(corr_up), 0);
    chk("R4 prop cleared", int'(prop_ctl), 0);
    send(1'b1, 1'b0, 1'b1, 1'b1);
    @(posedge clk); #1;
    chk("R4 err cleared", int'(err_flag), 0);
    chk("R5 freq held idle", int'(freq_ctl), exp_int);
  endtask

  task automatic t_window;  // R9
    send(1'b0, 1'b1, 1'b1, 1'b0);
    send(1'b1, 1'b1, 1'b0, 1'b0);
    send(1'b1, 1'b0, 1'b1, 1'b0);
    chk("R9 freq untouched", int'(freq_ctl), exp_int);
  endtask

  task automatic t_saturation;  // R6
    for (int i = 0; i < 140; i++) send(1'b0, 1'b1, 1'b1, 1'b1);
    chk("R6 upper rail", int'(freq_ctl), MAXV);
    for (int i = 0; i < 270; i++) send(1'b1, 1'b1, 1'b0, 1'b1);
    chk("R6 lower rail", int'(freq_ctl), MINV);
    for (int i = 0; i < 5; i++) send(1'b0, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_long_run;  // R12
    int start;
    start = exp_int;
    for (int i = 0; i < 2100; i++) send(i[3], i[0] ^ i[3], i[3], 1'b1);
    chk("R12 run kept freq", int'(freq_ctl), start);
  endtask

  task automatic t_backpressure;  // R10
    logic signed [INT_W-1:0] held;
    @(negedge clk); m_ready = 1'b1; s_valid = 1'b0;
    @(posedge clk); #1;
    chk("R10 drained", int'(m_valid), 0);
    @(negedge clk);
    m_ready = 1'b0; s_valid = 1'b1; s_a = 1'b1; s_t = 1'b1; s_b = 1'b0; win_ok = 1'b1;
    @(posedge clk); #1;
    if (exp_int > MINV) exp_int--;
    chk("R10 first beat data", int'(m_data), 1);
    chk("R10 ready low on stall", int'(s_ready), 0);
    s_a = 1'b0; s_t = 1'b1; s_b = 1'b1;
    held = freq_ctl;
    @(posedge clk); #1;
    chk("R10 data held", int'(m_data), 1);
    chk("R10 no pulse while stalled", int'(corr_up | corr_dn), 0);
    chk("R10 freq held", int'(freq_ctl), int'(held));
    @(negedge clk); m_ready = 1'b1;
    #1 chk("R10 ready on drain", int'(s_ready), 1);
    @(posedge clk); #1;
    s_valid = 1'b0;
    if (exp_int < MAXV) exp_int++;
    chk("R10 second beat data", int'(m_data), 0);
    chk("R3 up after stall", int'(corr_up), 1);
    chk("R5 freq after stall", int'(freq_ctl), exp_int);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_no_transition();
    t_early_late();
    t_pulse_width();
    t_window();
    t_saturation();
    t_long_run();
    t_backpressure();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule